// File: doc/BRIEF.md
# Protected-Mode Segment Register Load Checker

This block decides whether a protected-mode segment register load may complete. Each request names a target, which is either the stack segment slot or one of `N_DATA` data segment slots. The request also carries a 16-bit selector, the current privilege level, the byte limit of the descriptor table and the descriptor's access-rights byte. The block runs the protection checks in a fixed priority order. It then either commits the selector into the target slot or reports one fault class together with a 16-bit error code. Only the first failing check is reported.

The selector is split as index in bits 15:3, table indicator in bit 2 and requested privilege (RPL) in bits 1:0. The access-rights byte is read as follows:
- bit 7: present
- bits 6:5: descriptor privilege (DPL)
- bit 4: code/data descriptor when 1
- bit 3: executable
- bit 2: conforming (code) or expand-down (data)
- bit 1: readable (code) or writable (data)

A successful stack load opens a one-instruction window in which interrupts are held off. The window closes when the following instruction retires. Descriptor fetch is outside this block: the surrounding logic supplies the access-rights byte.

All outputs are registered and appear in the cycle after the clock edge that samples `load_req`. `seg_valid` bit 0 and `seg_sel[15:0]` belong to the stack slot. Data slot k uses `seg_valid[k+1]` and `seg_sel[(k+1)*16 +: 16]`.

Top module: `seg_load_check`

## Requirements
- R1: After reset all slot selectors and valid bits are 0, `commit` and `fault_valid` are 0, `fault_class` is 0 and `irq_inhibit` is 0.
- R2: A selector whose bits 15:2 are all zero (values 0x0000 to 0x0003) counts as null. A null selector sent to the stack slot gives `fault_class` 1 (general protection) with `fault_code` 0.
- R3: A null selector sent to a data slot commits without a fault. The selector is stored and that slot's valid bit is cleared.
- R4: For a non-null selector, if `{sel[15:3],3'b111}` is greater than `tbl_limit`, the result is a general-protection fault with `fault_code` equal to the selector. This check ranks above the type, privilege and present checks.
- R5: For the stack slot, all of the following must hold: RPL equals CPL; access-rights bits 4:3 are 2'b10 with bit 1 set (a writable data segment); DPL equals CPL. Any failure gives a general-protection fault carrying the selector.
- R6: A stack descriptor that passes R4 and R5 but has bit 7 clear gives `fault_class` 2 (stack fault) with the selector as code.
- R7: For a data slot, the descriptor must be a data segment (bits 4:3 = 2'b10) or a readable code segment (bits 4:3 = 2'b11 with bit 1 set). Otherwise the result is a general-protection fault carrying the selector.
- R8: For a data slot holding a data segment or a nonconforming code segment, both RPL and CPL must be less than or equal to DPL, or a general-protection fault results. A conforming code segment (bits 3 and 2 set) skips this check.
- R9: A data-slot descriptor that passes R4, R7 and R8 but has bit 7 clear gives `fault_class` 3 (not present) with the selector as code.
- R10: A load that passes every check pulses `commit` for one cycle. The selector is stored in the target slot, shown on `commit_sel`, and the slot's valid bit is set.
- R11: A faulting load pulses `fault_valid` for one cycle and leaves every slot selector and valid bit unchanged. `commit` and `fault_valid` are never high together.
- R12: A committed stack load sets `irq_inhibit`. A cycle with `retire` high and no new committed stack load clears it. Data loads and faults leave it unchanged.
- R13: A cycle with `load_req` low gives no commit, `fault_class` 0 and `fault_code` 0, and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | A segment load is requested this cycle |
| tgt_stack | input | 1 | 1 selects the stack slot, 0 selects the data slot `data_idx` |
| data_idx | input | IDX_W | Data slot number when `tgt_stack` is 0 |
| sel_in | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| tbl_limit | input | 16 | Descriptor table byte limit |
| ar_byte | input | 8 | Descriptor access-rights byte |
| retire | input | 1 | An instruction retires this cycle |
| commit | output | 1 | One-cycle pulse for a committed load |
| commit_sel | output | 16 | Selector of the most recent committed load |
| seg_sel | output | (N_DATA+1)*16 | All slot selectors, stack slot lowest |
| seg_valid | output | N_DATA+1 | Descriptor-valid bit per slot, stack slot in bit 0 |
| fault_valid | output | 1 | One-cycle pulse for a faulting load |
| fault_class | output | 2 | 0 none, 1 general protection, 2 stack, 3 not present |
| fault_code | output | 16 | Error code of the reported fault, 0 otherwise |
| irq_inhibit | output | 1 | Interrupts held off |

## Verification
The hardest case to reach is the stack fault of R6. It needs every earlier stack check to pass: RPL and DPL both equal to CPL, a writable data type and an in-limit index, with only the present bit clear. Uniform random fields almost never line all of these up. About half of the random vectors are therefore shaped: RPL is copied from CPL, DPL is chosen at or above the needed level, the type comes from a short list of legal encodings, and the present bit is left random. Directed vectors cover the limit boundary, where an end offset equal to the limit passes and one more byte faults. They also cover conforming code at a low DPL, and a retire that arrives in the same cycle as a new stack commit.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int SEL_W = 16;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_GP   = 2'd1,
    FC_SS   = 2'd2,
    FC_NP   = 2'd3
  } fault_cls_e;

  function automatic logic sel_null(input logic [SEL_W-1:0] s);
    return (s[SEL_W-1:2] == '0);
  endfunction

  // last byte of the 8-byte descriptor lies past the table limit
  function automatic logic sel_past_limit(input logic [SEL_W-1:0] s,
                                          input logic [SEL_W-1:0] lim);
    return ({s[SEL_W-1:3], 3'b111} > lim);
  endfunction

  function automatic logic ar_present(input logic [7:0] ar);
    return ar[7];
  endfunction

  function automatic logic [1:0] ar_dpl(input logic [7:0] ar);
    return ar[6:5];
  endfunction

  function automatic logic ar_is_data(input logic [7:0] ar);
    return ar[4] && !ar[3];
  endfunction

  function automatic logic ar_is_code(input logic [7:0] ar);
    return ar[4] && ar[3];
  endfunction

  function automatic logic ar_rw(input logic [7:0] ar);
    return ar[1];
  endfunction

  function automatic logic ar_conforming(input logic [7:0] ar);
    return ar[2];
  endfunction
endpackage

// File: rtl/seg_rules.sv
module seg_rules
  import seg_chk_pkg::*;
(
  input  logic             tgt_stack,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       cpl,
  input  logic [SEL_W-1:0] limit,
  input  logic [7:0]       ar,
  output fault_cls_e       cls,
  output logic [SEL_W-1:0] code,
  output logic             null_hit,
  output logic             limit_hit,
  output logic             rule_hit,
  output logic             absent_hit
);
  logic [1:0] rpl;
  logic [1:0] dpl;
  logic       stk_type_ok, stk_priv_ok;
  logic       dat_type_ok, dat_priv_ok;

  assign rpl = sel[1:0];
  assign dpl = ar_dpl(ar);

  assign stk_type_ok = ar_is_data(ar) && ar_rw(ar);
  assign stk_priv_ok = (rpl == cpl) && (dpl == cpl);

  assign dat_type_ok = ar_is_data(ar) || (ar_is_code(ar) && ar_rw(ar));
  assign dat_priv_ok = (ar_is_code(ar) && ar_conforming(ar)) ||
                       ((rpl <= dpl) && (cpl <= dpl));

  assign null_hit   = sel_null(sel);
  assign limit_hit  = !null_hit && sel_past_limit(sel, limit);
  assign rule_hit   = !null_hit && !limit_hit &&
                      (tgt_stack ? !(stk_type_ok && stk_priv_ok)
                                 : !(dat_type_ok && dat_priv_ok));
  assign absent_hit = !null_hit && !limit_hit && !rule_hit && !ar_present(ar);

  always_comb begin
    cls  = FC_NONE;
    code = '0;
    if (null_hit) begin
      if (tgt_stack) cls = FC_GP;
    end else if (limit_hit || rule_hit) begin
      cls  = FC_GP;
      code = sel;
    end else if (absent_hit) begin
      cls  = tgt_stack ? FC_SS : FC_NP;
      code = sel;
    end
  end
endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import seg_chk_pkg::*;
#(
  parameter int N_SLOT = 5,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic                    wr_valid,
  output logic [N_SLOT*SEL_W-1:0] sel_flat,
  output logic [N_SLOT-1:0]       valid
);
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_flat[g*SEL_W +: SEL_W] <= '0;
        valid[g]                   <= 1'b0;
      end else if (hit) begin
        sel_flat[g*SEL_W +: SEL_W] <= wr_sel;
        valid[g]                   <= wr_valid;
      end
    end
  end

  // R10 / R3: written slot takes the requested selector and valid bit
  a_r10_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid[$past(wr_slot)] == $past(wr_valid)) &&
              (sel_flat[$past(wr_slot)*SEL_W +: SEL_W] == $past(wr_sel)));
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic inhibit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     inhibit <= 1'b0;
    else if (set_i) inhibit <= 1'b1;
    else if (clr_i) inhibit <= 1'b0;
  end

  a_r12_rise_from_stack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> $past(set_i));
  a_r12_fall_from_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> $past(clr_i) && !$past(set_i));
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_chk_pkg::*;
#(
  parameter int N_DATA = 4,
  localparam int IDX_W  = (N_DATA > 1) ? $clog2(N_DATA) : 1,
  localparam int N_SLOT = N_DATA + 1,
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_req,
  input  logic                    tgt_stack,
  input  logic [IDX_W-1:0]        data_idx,
  input  logic [15:0]             sel_in,
  input  logic [1:0]              cpl,
  input  logic [15:0]             tbl_limit,
  input  logic [7:0]              ar_byte,
  input  logic                    retire,
  output logic                    commit,
  output logic [15:0]             commit_sel,
  output logic [N_SLOT*16-1:0]    seg_sel,
  output logic [N_SLOT-1:0]       seg_valid,
  output logic                    fault_valid,
  output logic [1:0]              fault_class,
  output logic [15:0]             fault_code,
  output logic                    irq_inhibit
);
  fault_cls_e       rule_cls;
  logic [15:0]      rule_code;
  logic             null_hit, limit_hit, rule_hit, absent_hit;
  logic             load_ok, load_bad, stack_commit;
  logic [SLOT_W-1:0] slot;

  seg_rules u_rules (
    .tgt_stack (tgt_stack),
    .sel       (sel_in),
    .cpl       (cpl),
    .limit     (tbl_limit),
    .ar        (ar_byte),
    .cls       (rule_cls),
    .code      (rule_code),
    .null_hit  (null_hit),
    .limit_hit (limit_hit),
    .rule_hit  (rule_hit),
    .absent_hit(absent_hit)
  );

  assign slot         = tgt_stack ? '0 : (SLOT_W'(data_idx) + SLOT_W'(1));
  assign load_ok      = load_req && (rule_cls == FC_NONE);
  assign load_bad     = load_req && (rule_cls != FC_NONE);
  assign stack_commit = load_ok && tgt_stack;

  seg_bank #(.N_SLOT(N_SLOT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_ok),
    .wr_slot (slot),
    .wr_sel  (sel_in),
    .wr_valid(!null_hit),
    .sel_flat(seg_sel),
    .valid   (seg_valid)
  );

  irq_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stack_commit),
    .clr_i  (retire),
    .inhibit(irq_inhibit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit      <= 1'b0;
      commit_sel  <= '0;
      fault_valid <= 1'b0;
      fault_class <= FC_NONE;
      fault_code  <= '0;
    end else begin
      commit      <= load_ok;
      fault_valid <= load_bad;
      fault_class <= load_req ? rule_cls : FC_NONE;
      fault_code  <= load_bad ? rule_code : '0;
      if (load_ok) commit_sel <= sel_in;
    end
  end

  a_r2_null_stack_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && tgt_stack && sel_in[15:2] == '0) |=>
      (fault_class == FC_GP) && (fault_code == '0));

  a_r3_null_data_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !tgt_stack && sel_in[15:2] == '0) |=>
      commit && !seg_valid[$past(slot)]);

  a_r4_code_is_selector: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && sel_in[15:2] != '0) |=>
      (fault_class == FC_NONE) || (fault_code == $past(sel_in)));

  a_r6_stack_fault_stack_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_class == FC_SS) |-> $past(tgt_stack));

  a_r9_np_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_class == FC_NP) |-> !$past(tgt_stack));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && fault_valid));

  a_r11_fault_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (seg_valid == $past(seg_valid)) && (seg_sel == $past(seg_sel)));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> !commit && !fault_valid && (fault_code == '0));
endmodule

// File: tb/seg_load_check_tb_top.sv
module seg_load_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_DATA     = 4;
  localparam int N_SLOT     = N_DATA + 1;
  localparam int IDX_W      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 1'b0, tgt_stack = 1'b0, retire = 1'b0;
  logic [IDX_W-1:0] data_idx = '0;
  logic [15:0] sel_in = '0, tbl_limit = '0;
  logic [1:0]  cpl = '0;
  logic [7:0]  ar_byte = '0;
  logic commit, fault_valid, irq_inhibit;
  logic [15:0] commit_sel, fault_code;
  logic [N_SLOT*16-1:0] seg_sel;
  logic [N_SLOT-1:0] seg_valid;
  logic [1:0] fault_class;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] m_sel [N_SLOT];
  logic        m_val [N_SLOT];
  logic        m_inh;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_load_check #(.N_DATA(N_DATA)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .tgt_stack(tgt_stack),
    .data_idx(data_idx), .sel_in(sel_in), .cpl(cpl), .tbl_limit(tbl_limit),
    .ar_byte(ar_byte), .retire(retire), .commit(commit), .commit_sel(commit_sel),
    .seg_sel(seg_sel), .seg_valid(seg_valid), .fault_valid(fault_valid),
    .fault_class(fault_class), .fault_code(fault_code), .irq_inhibit(irq_inhibit)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // independent statement of the protection rules
  function automatic void ref_eval(input logic stk, input logic [15:0] sel,
      input logic [1:0] c, input logic [15:0] lim, input logic [7:0] ar,
      output logic [1:0] cls, output logic [15:0] code, output string tag);
    logic [1:0] rp, dp;
    bit legal, priv;
    rp = sel[1:0];
    dp = ar[6:5];
    cls = 2'd0; code = 16'd0; tag = "R10";
    if (sel < 16'd4) begin
      if (stk) begin cls = 2'd1; tag = "R2"; end
      else tag = "R3";
      return;
    end
    if ((sel | 16'h0007) > lim) begin cls = 2'd1; code = sel; tag = "R4"; return; end
    if (stk) begin
      legal = (ar[4:3] == 2'b10) && ar[1];
      if (rp != c || !legal || dp != c) begin cls = 2'd1; code = sel; tag = "R5"; return; end
      if (!ar[7]) begin cls = 2'd2; code = sel; tag = "R6"; return; end
    end else begin
      case (ar[4:3])
        2'b10:   legal = 1;
        2'b11:   legal = ar[1];
        default: legal = 0;
      endcase
      if (!legal) begin cls = 2'd1; code = sel; tag = "R7"; return; end
      if (ar[3] && ar[2]) priv = 1;
      else priv = (rp <= dp) && (c <= dp);
      if (!priv) begin cls = 2'd1; code = sel; tag = "R8"; return; end
      if (!ar[7]) begin cls = 2'd3; code = sel; tag = "R9"; return; end
    end
  endfunction

  task automatic check_bank(input string tag);
    logic [N_SLOT*16-1:0] es;
    logic [N_SLOT-1:0]    ev;
    for (int k = 0; k < N_SLOT; k++) begin
      es[k*16 +: 16] = m_sel[k];
      ev[k]          = m_val[k];
    end
    chk(seg_sel == es, tag, "seg_sel", 128'(seg_sel), 128'(es));
    chk(seg_valid == ev, tag, "seg_valid", 128'(seg_valid), 128'(ev));
  endtask

  task automatic apply(input logic req, input logic stk, input logic [IDX_W-1:0] idx,
      input logic [15:0] sel, input logic [1:0] c, input logic [15:0] lim,
      input logic [7:0] ar, input logic ret);
    logic [1:0] ecls;
    logic [15:0] ecode;
    string tag;
    int slot;
    load_req = req; tgt_stack = stk; data_idx = idx; sel_in = sel;
    cpl = c; tbl_limit = lim; ar_byte = ar; retire = ret;
    @(posedge clk);
    @(negedge clk);
    load_req = 1'b0; retire = 1'b0;
    slot = stk ? 0 : int'(idx) + 1;
    if (req) begin
      ref_eval(stk, sel, c, lim, ar, ecls, ecode, tag);
      if (ecls == 2'd0) begin
        m_sel[slot] = sel;
        m_val[slot] = (sel >= 16'd4);
      end
    end else begin
      ecls = 2'd0; ecode = 16'd0; tag = "R13";
    end
    if (req && stk && ecls == 2'd0) m_inh = 1'b1;
    else if (ret) m_inh = 1'b0;
    chk(commit == (req && ecls == 2'd0), tag, "commit", 128'(commit), 128'(req && ecls == 2'd0));
    chk(fault_valid == (ecls != 2'd0), tag, "fault_valid", 128'(fault_valid), 128'(ecls != 2'd0));
    chk(fault_class == ecls, tag, "fault_class", 128'(fault_class), 128'(ecls));
    chk(fault_code == ecode, tag, "fault_code", 128'(fault_code), 128'(ecode));
    if (req && ecls == 2'd0)
      chk(commit_sel == sel, "R10", "commit_sel", 128'(commit_sel), 128'(sel));
    check_bank((ecls != 2'd0) ? "R11" : tag);
    chk(irq_inhibit == m_inh, "R12", "irq_inhibit", 128'(irq_inhibit), 128'(m_inh));
  endtask

  function automatic logic [7:0] shaped_ar(input logic stk, input logic [1:0] rp,
                                           input logic [1:0] c);
    logic [3:0] ty;
    logic [1:0] lo, dp;
    case ($urandom_range(0, 4))
      0: ty = 4'b1001;
      1: ty = 4'b1011;
      2: ty = 4'b1101;
      3: ty = 4'b1111;
      default: ty = 4'b1000;
    endcase
    if (stk) begin
      dp = c;
      ty = ($urandom_range(0, 3) == 0) ? ty : 4'b1001;
    end else begin
      lo = (rp > c) ? rp : c;
      dp = 2'($urandom_range(int'(lo), 3));
    end
    return {($urandom_range(0, 2) != 0), dp, ty, 1'($urandom_range(0, 1))};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5e61_0ad5));
    for (int k = 0; k < N_SLOT; k++) begin m_sel[k] = '0; m_val[k] = 1'b0; end
    m_inh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(commit == 1'b0 && fault_valid == 1'b0, "R1", "pulses", 128'({commit, fault_valid}), 128'(0));
    chk(fault_class == 2'd0, "R1", "fault_class", 128'(fault_class), 128'(0));
    chk(irq_inhibit == 1'b0, "R1", "irq_inhibit", 128'(irq_inhibit), 128'(0));
    check_bank("R1");

    // R2 null into stack, R3 null into data slot 2
    apply(1, 1, 2'd0, 16'h0002, 2'd0, 16'h00ff, 8'h93, 0);
    apply(1, 0, 2'd2, 16'h0003, 2'd3, 16'h00ff, 8'h00, 0);
    // R10 data load, then R3 overwrites it and clears valid
    apply(1, 0, 2'd1, 16'h0010, 2'd0, 16'h0017, 8'h93, 0);
    apply(1, 0, 2'd1, 16'h0001, 2'd0, 16'h0017, 8'h93, 0);
    // R4 limit boundary: end offset 0x17 vs limit 0x16
    apply(1, 0, 2'd0, 16'h0010, 2'd0, 16'h0016, 8'h93, 0);
    // R4 ranks above a type failure
    apply(1, 0, 2'd0, 16'h0018, 2'd0, 16'h0010, 8'h00, 0);
    // R12 stack commit with retire in the same cycle keeps inhibit
    apply(1, 1, 2'd0, 16'h0013, 2'd3, 16'h00ff, 8'hf3, 1);
    apply(0, 0, 2'd0, 16'h0000, 2'd0, 16'h0000, 8'h00, 0);
    apply(1, 0, 2'd3, 16'h0020, 2'd0, 16'h00ff, 8'h93, 0);
    apply(0, 0, 2'd0, 16'h0000, 2'd0, 16'h0000, 8'h00, 1);
    // R6 stack not present, R5 DPL mismatch
    apply(1, 1, 2'd0, 16'h0008, 2'd0, 16'h00ff, 8'h13, 0);
    apply(1, 1, 2'd0, 16'h0008, 2'd0, 16'h00ff, 8'hb3, 0);
    // R8 conforming code with DPL 0 accepted at CPL 3, nonconforming refused
    apply(1, 0, 2'd0, 16'h000b, 2'd3, 16'h00ff, 8'h9e, 0);
    apply(1, 0, 2'd0, 16'h000b, 2'd3, 16'h00ff, 8'h9a, 0);
    // R7 execute-only code, R9 data not present
    apply(1, 0, 2'd1, 16'h0008, 2'd0, 16'h00ff, 8'h98, 0);
    apply(1, 0, 2'd1, 16'h0008, 2'd0, 16'h00ff, 8'h13, 0);

    for (int v = 0; v < 4000; v++) begin
      logic stk, req;
      logic [1:0] c, rp;
      logic [15:0] sel, lim;
      logic [7:0] ar;
      req = ($urandom_range(0, 9) != 0);
      stk = ($urandom_range(0, 2) == 0);
      c   = 2'($urandom_range(0, 3));
      rp  = 2'($urandom_range(0, 3));
      lim = 16'($urandom_range(0, 383));
      if ($urandom_range(0, 9) == 0) sel = {14'd0, rp};
      else sel = {13'($urandom_range(0, 47)), 1'($urandom_range(0, 1)), rp};
      if ($urandom_range(0, 1) == 1) begin
        if (stk) sel[1:0] = c;
        ar = shaped_ar(stk, sel[1:0], c);
        lim = 16'h0187;
      end else begin
        ar = 8'($urandom);
      end
      apply(req, stk, 2'($urandom_range(0, 3)), sel, c, lim, ar,
            ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule